// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Selectable Replacement

The block is a read-allocate cache in which every set holds two ways, each way carrying a valid flag, an address tag and a data block of several words. A lookup compares the two stored tags of the addressed set at the same time. A hit returns the requested word one cycle after the request is taken. A miss asks a lower-level memory for the whole block, installs it into a victim way and then returns the requested word from the arriving block.

The victim way is chosen by a policy fixed when the block is elaborated. The choices are oldest fill (first in, first out), least recently used, and pseudo-random. FIFO and LRU each keep one state bit per set; the random mode draws on a free-running shift register. An empty way is always filled before any policy is consulted. The block is meant to sit between a requester that issues one read at a time and a memory that returns whole blocks.

Top module: `cache2w`

## Requirements
- R1: After reset every way is invalid, `req_ready` is 1, and `fill_req` and `resp_valid` are 0; the first access to any address is a miss.
- R2: With default parameters the address splits as: bits [1:0] byte within a word (ignored), bit [2] word within the block, bits [4:3] set index, bits [15:5] tag; two addresses differing only in bits [1:0] return the same word.
- R3: A request taken (`req_valid` and `req_ready`) whose tag matches a valid way of its set gives `resp_valid`=1 and `resp_hit`=1 on the next cycle, with `resp_data` equal to the selected word of that block.
- R4: A request that misses raises `fill_req` on the next cycle with `fill_addr` equal to the request address with bits [2:0] cleared; `fill_req` and `fill_addr` hold and `req_ready` stays 0 until `fill_valid` is seen.
- R5: On the cycle `fill_valid` is seen the block on `fill_data` (word k in bits [32k+31:32k]) is written into the victim way; on the next cycle `resp_valid`=1, `resp_hit`=0 and `resp_data` is the requested word of that block, and later requests to the block hit.
- R6: If way 0 of the set is invalid it is the victim; otherwise if way 1 is invalid it is the victim; only when both are valid does the policy decide.
- R7: In FIFO mode the victim is the way filled earlier; hits do not change the choice.
- R8: In LRU mode the victim is the way whose last hit or fill is older.
- R9: In random mode an 8-bit shift register is loaded with 0x01 in reset and advances every cycle to {s[6:0], s[7]^s[5]^s[4]^s[3]}; the victim is bit 0 of the value held in the cycle the missing request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | Block can take a request this cycle |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | 1 when the response came from a stored block |
| resp_data | output | WORD_W | Returned word |
| fill_req | output | 1 | Block wants a block from lower memory |
| fill_addr | output | ADDR_W | Block-aligned address being fetched |
| fill_valid | input | 1 | Lower memory delivers the block this cycle |
| fill_data | input | WORDS*WORD_W | Delivered block, word 0 in the low bits |

## Verification
The assertions take for granted that the lower memory pulses `fill_valid` for exactly one cycle and only while `fill_req` is high, and that the requester only counts a request as taken when `req_ready` is high. The stimulus keeps to this: the memory model answers each fill request once after a latency of zero to two cycles and drops its strobe when the request falls, and requests are issued one at a time only after every previous response has arrived. Eviction order is exposed through hit and miss patterns on a single crowded set, and then on a random mix of a few tags over all sets, run in all three policies side by side.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    // Victim selection policies, chosen at elaboration.
    typedef enum logic [1:0] {
        REPL_FIFO = 2'd0,
        REPL_LRU  = 2'd1,
        REPL_RAND = 2'd2
    } repl_e;

    // Controller states.
    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_REFILL = 1'b1
    } ctrl_st_e;

    localparam int LFSR_W = 8;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;

    // One step of the random source: shift left, feedback from taps 7,5,4,3.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/cache2w_ways.sv
// Storage of the two ways: valid flags, tags and data blocks per set.
// Assumes SETS is a power of two matching IDX_W. One write port, one
// combinational read port addressed by set index.
module cache2w_ways #(
    parameter int SETS  = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 11,
    parameter int BLK_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [1:0]                rd_valid,
    output logic [1:0][TAG_W-1:0]     rd_tag,
    output logic [1:0][BLK_W-1:0]     rd_data,
    input  logic                      wr_en,
    input  logic                      wr_way,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [TAG_W-1:0]          wr_tag,
    input  logic [BLK_W-1:0]          wr_data
);

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]  vld;
        logic [TAG_W-1:0] tags [SETS];
        logic [BLK_W-1:0] blks [SETS];
        logic             sel;

        assign sel = wr_en && (wr_way == 1'(w));

        // Valid flags: cleared by reset, set when a block is installed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= '0;
            end else if (sel) begin
                vld[wr_idx] <= 1'b1;
            end
        end

        // Tag and data arrays: written on install, no reset needed.
        always_ff @(posedge clk) begin
            if (sel) begin
                tags[wr_idx] <= wr_tag;
                blks[wr_idx] <= wr_data;
            end
        end

        assign rd_valid[w] = vld[rd_idx];
        assign rd_tag[w]   = tags[rd_idx];
        assign rd_data[w]  = blks[rd_idx];
    end

endmodule

// File: rtl/cache2w_repl.sv
// Victim selection for a two-way set. Empty ways win first (way 0 before
// way 1); otherwise the elaborated policy decides. FIFO and LRU keep one
// bit per set naming the way to evict next; random uses a free-running LFSR.
// Assumes touch_hit and touch_fill are never high in the same cycle.
module cache2w_repl
    import cache2w_pkg::*;
#(
    parameter repl_e POLICY = REPL_LRU,
    parameter int    SETS   = 4,
    parameter int    IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [1:0]       look_valid,
    output logic             victim,
    input  logic             touch_hit,
    input  logic             touch_fill,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way
);

    logic pick;

    // Empty way first, then the policy's choice.
    always_comb begin
        if (!look_valid[0])      victim = 1'b0;
        else if (!look_valid[1]) victim = 1'b1;
        else                     victim = pick;
    end

    if (POLICY == REPL_RAND) begin : g_rand
        logic [LFSR_W-1:0] lfsr;

        // Free-running random source, advances every cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) lfsr <= LFSR_SEED;
            else        lfsr <= lfsr_step(lfsr);
        end

        assign pick = lfsr[0];
    end else begin : g_state
        logic [SETS-1:0] evict_next;
        logic            upd;

        // LRU moves on hits and fills, FIFO only on fills.
        assign upd = touch_fill || ((POLICY == REPL_LRU) && touch_hit);

        // Per-set state: the way not just touched is the next victim.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evict_next <= '0;
            end else if (upd) begin
                evict_next[touch_idx] <= ~touch_way;
            end
        end

        assign pick = evict_next[look_idx];
    end

endmodule

// File: rtl/cache2w_ctrl.sv
// Request sequencing: answers hits one cycle after acceptance, turns a miss
// into a block fetch, installs the arriving block and answers from it.
// Assumes fill_valid only arrives while fill_req is high.
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 2,
    parameter int IDX_W   = 2,
    parameter int TAG_W   = 11,
    parameter int WSEL_W  = 1,
    parameter int BLK_OFF = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [TAG_W-1:0]        req_tag,
    input  logic [IDX_W-1:0]        req_idx,
    input  logic [WSEL_W-1:0]       req_wsel,
    input  logic                    lk_hit,
    input  logic                    lk_way,
    input  logic [WORD_W-1:0]       lk_word,
    input  logic                    victim,
    input  logic                    fill_valid,
    input  logic [WORDS*WORD_W-1:0] fill_data,
    output logic                    req_ready,
    output logic                    resp_valid,
    output logic                    resp_hit,
    output logic [WORD_W-1:0]       resp_data,
    output logic                    fill_req,
    output logic [ADDR_W-1:0]       fill_addr,
    output logic                    wr_en,
    output logic                    wr_way,
    output logic [IDX_W-1:0]        wr_idx,
    output logic [TAG_W-1:0]        wr_tag,
    output logic                    touch_hit,
    output logic                    touch_fill,
    output logic [IDX_W-1:0]        touch_idx,
    output logic                    touch_way
);

    ctrl_st_e           st;
    logic [IDX_W-1:0]   miss_idx;
    logic [TAG_W-1:0]   miss_tag;
    logic [WSEL_W-1:0]  miss_wsel;
    logic               miss_way;
    logic               accept;
    logic [WORD_W-1:0]  fill_word;

    assign req_ready = (st == ST_LOOKUP);
    assign accept    = req_valid && req_ready;
    assign fill_word = fill_data[miss_wsel*WORD_W +: WORD_W];

    // Install and policy-update strobes derived from the current state.
    always_comb begin
        wr_en      = (st == ST_REFILL) && fill_valid;
        wr_way     = miss_way;
        wr_idx     = miss_idx;
        wr_tag     = miss_tag;
        touch_hit  = accept && lk_hit;
        touch_fill = wr_en;
        touch_idx  = (st == ST_REFILL) ? miss_idx : req_idx;
        touch_way  = (st == ST_REFILL) ? miss_way : lk_way;
    end

    // Main sequencer: lookup, fetch on miss, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_LOOKUP;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
            fill_req   <= 1'b0;
            fill_addr  <= '0;
            miss_idx   <= '0;
            miss_tag   <= '0;
            miss_wsel  <= '0;
            miss_way   <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            unique case (st)
                ST_LOOKUP: begin
                    if (accept) begin
                        if (lk_hit) begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b1;
                            resp_data  <= lk_word;
                        end else begin
                            st        <= ST_REFILL;
                            fill_req  <= 1'b1;
                            fill_addr <= {req_tag, req_idx, {BLK_OFF{1'b0}}};
                            miss_idx  <= req_idx;
                            miss_tag  <= req_tag;
                            miss_wsel <= req_wsel;
                            miss_way  <= victim;
                        end
                    end
                end
                ST_REFILL: begin
                    if (fill_valid) begin
                        st         <= ST_LOOKUP;
                        fill_req   <= 1'b0;
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_data  <= fill_word;
                    end
                end
                default: st <= ST_LOOKUP;
            endcase
        end
    end

endmodule

// File: rtl/cache2w.sv
// Two-way set-associative read cache with elaboration-time replacement
// policy. Splits the address, compares both ways in parallel, muxes the
// hitting word and hands misses to the sequencer. Assumes WORDS >= 2,
// SETS a power of two and WORD_W a multiple of 8.
module cache2w
    import cache2w_pkg::*;
#(
    parameter int    ADDR_W = 16,
    parameter int    WORD_W = 32,
    parameter int    WORDS  = 2,
    parameter int    SETS   = 4,
    parameter repl_e POLICY = REPL_LRU
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    req_ready,
    output logic                    resp_valid,
    output logic                    resp_hit,
    output logic [WORD_W-1:0]       resp_data,
    output logic                    fill_req,
    output logic [ADDR_W-1:0]       fill_addr,
    input  logic                    fill_valid,
    input  logic [WORDS*WORD_W-1:0] fill_data
);

    localparam int BYTE_OFF = $clog2(WORD_W / 8);
    localparam int WSEL_W   = $clog2(WORDS);
    localparam int IDX_W    = $clog2(SETS);
    localparam int BLK_OFF  = BYTE_OFF + WSEL_W;
    localparam int TAG_W    = ADDR_W - BLK_OFF - IDX_W;
    localparam int BLK_W    = WORDS * WORD_W;

    logic [TAG_W-1:0]          req_tag;
    logic [IDX_W-1:0]          req_idx;
    logic [WSEL_W-1:0]         req_wsel;
    logic [1:0]                way_valid;
    logic [1:0][TAG_W-1:0]     way_tag;
    logic [1:0][BLK_W-1:0]     way_data;
    logic [1:0]                way_match;
    logic [1:0][WORD_W-1:0]    way_word;
    logic                      lk_hit;
    logic                      lk_way;
    logic [WORD_W-1:0]         lk_word;
    logic                      victim;
    logic                      wr_en;
    logic                      wr_way;
    logic [IDX_W-1:0]          wr_idx;
    logic [TAG_W-1:0]          wr_tag;
    logic                      touch_hit;
    logic                      touch_fill;
    logic [IDX_W-1:0]          touch_idx;
    logic                      touch_way;

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[BLK_OFF +: IDX_W];
    assign req_wsel = req_addr[BYTE_OFF +: WSEL_W];

    cache2w_ways #(
        .SETS  (SETS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .BLK_W (BLK_W)
    ) u_ways (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_valid (way_valid),
        .rd_tag   (way_tag),
        .rd_data  (way_data),
        .wr_en    (wr_en),
        .wr_way   (wr_way),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_data  (fill_data)
    );

    // Parallel tag compare and word select, one per way.
    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign way_match[w] = way_valid[w] && (way_tag[w] == req_tag);
        assign way_word[w]  = way_data[w][req_wsel*WORD_W +: WORD_W];
    end

    assign lk_hit  = |way_match;
    assign lk_way  = way_match[1];
    assign lk_word = way_match[1] ? way_word[1] : way_word[0];

    cache2w_repl #(
        .POLICY (POLICY),
        .SETS   (SETS),
        .IDX_W  (IDX_W)
    ) u_repl (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_idx   (req_idx),
        .look_valid (way_valid),
        .victim     (victim),
        .touch_hit  (touch_hit),
        .touch_fill (touch_fill),
        .touch_idx  (touch_idx),
        .touch_way  (touch_way)
    );

    cache2w_ctrl #(
        .ADDR_W  (ADDR_W),
        .WORD_W  (WORD_W),
        .WORDS   (WORDS),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .WSEL_W  (WSEL_W),
        .BLK_OFF (BLK_OFF)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_tag    (req_tag),
        .req_idx    (req_idx),
        .req_wsel   (req_wsel),
        .lk_hit     (lk_hit),
        .lk_way     (lk_way),
        .lk_word    (lk_word),
        .victim     (victim),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_data  (resp_data),
        .fill_req   (fill_req),
        .fill_addr  (fill_addr),
        .wr_en      (wr_en),
        .wr_way     (wr_way),
        .wr_idx     (wr_idx),
        .wr_tag     (wr_tag),
        .touch_hit  (touch_hit),
        .touch_fill (touch_fill),
        .touch_idx  (touch_idx),
        .touch_way  (touch_way)
    );

endmodule

// File: rtl/cache2w_chk.sv
// Protocol and storage checks for cache2w, attached by bind.
// Assumes fill_valid is a one-cycle pulse given only while fill_req is high.
module cache2w_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              fill_req,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_valid,
    input logic [1:0]        way_match
);

    // R1: leaving reset, nothing is pending or answered
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!fill_req && !resp_valid && req_ready));

    // R3: a hit answer always follows a taken request
    a_r3_hit_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> $past(req_valid && req_ready));

    // R4: no request is taken while a block fetch is open
    a_r4_busy_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !req_ready);

    // R4: fetch address is held while the fetch stays open
    a_r4_fetch_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && $past(fill_req)) |-> $stable(fill_addr));

    // R5: a miss answer always follows a delivered block
    a_r5_miss_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> $past(fill_req && fill_valid));

    // R5: a block is installed in at most one way of its set
    a_r5_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_match));

endmodule

bind cache2w cache2w_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .fill_req   (fill_req),
    .fill_addr  (fill_addr),
    .fill_valid (fill_valid),
    .way_match  (way_match)
);

// File: tb/tb_cache2w.sv
module tb_cache2w;
    import cache2w_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_addr;
    logic        rdy [3];
    logic        rv  [3];
    logic        rh  [3];
    logic [31:0] rd  [3];
    logic        frq [3];
    logic [15:0] fa  [3];
    logic        fv  [3];
    logic [63:0] fd  [3];

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // index 0: FIFO, 1: LRU (dut), 2: random
    cache2w #(.POLICY(REPL_FIFO)) dut_fifo (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(rdy[0]), .resp_valid(rv[0]), .resp_hit(rh[0]), .resp_data(rd[0]),
        .fill_req(frq[0]), .fill_addr(fa[0]), .fill_valid(fv[0]), .fill_data(fd[0]));
    cache2w #(.POLICY(REPL_LRU)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(rdy[1]), .resp_valid(rv[1]), .resp_hit(rh[1]), .resp_data(rd[1]),
        .fill_req(frq[1]), .fill_addr(fa[1]), .fill_valid(fv[1]), .fill_data(fd[1]));
    cache2w #(.POLICY(REPL_RAND)) dut_rand (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(rdy[2]), .resp_valid(rv[2]), .resp_hit(rh[2]), .resp_data(rd[2]),
        .fill_req(frq[2]), .fill_addr(fa[2]), .fill_valid(fv[2]), .fill_data(fd[2]));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory content: a word is derived from its block address and position.
    function automatic logic [31:0] word_of(input logic [15:0] blk, input int k);
        return {blk, 8'h5A, 8'(k)};
    endfunction

    // Random source as stated in R9.
    logic [7:0] m_lfsr;
    always @(posedge clk) begin
        if (!rst_n) m_lfsr <= 8'h01;
        else        m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    end

    // Lower memory: answers each fetch once, latency 0..2 by address.
    int cnt [3];
    always @(negedge clk) begin
        for (int p = 0; p < 3; p++) begin
            if (!rst_n || !frq[p]) begin
                fv[p]  = 1'b0;
                cnt[p] = 0;
            end else if (!fv[p]) begin
                if (cnt[p] >= int'(fa[p][7:5]) % 3) begin
                    fv[p] = 1'b1;
                    fd[p] = {word_of(fa[p], 1), word_of(fa[p], 0)};
                end else begin
                    cnt[p]++;
                end
            end
        end
    end

    // Behavioural reference: per policy, per set, per way, with time stamps.
    bit mv    [3][4][2];
    int mtag  [3][4][2];
    int muse  [3][4][2];
    int mfill [3][4][2];
    int tick = 0;

    function automatic bit model_access(input int p, input logic [15:0] a, input bit rb);
        int s = int'(a[4:3]);
        int t = int'(a[15:5]);
        int v;
        tick++;
        for (int w = 0; w < 2; w++) begin
            if (mv[p][s][w] && mtag[p][s][w] == t) begin
                muse[p][s][w] = tick;
                return 1'b1;
            end
        end
        if (!mv[p][s][0])      v = 0;
        else if (!mv[p][s][1]) v = 1;
        else if (p == 0)       v = (mfill[p][s][0] < mfill[p][s][1]) ? 0 : 1;
        else if (p == 1)       v = (muse[p][s][0] < muse[p][s][1]) ? 0 : 1;
        else                   v = int'(rb);
        mv[p][s][v]    = 1'b1;
        mtag[p][s][v]  = t;
        muse[p][s][v]  = tick;
        mfill[p][s][v] = tick;
        return 1'b0;
    endfunction

    function automatic string pol_tag(input int p);
        return (p == 0) ? "R7" : ((p == 1) ? "R8" : "R9");
    endfunction

    // One read to all three caches; every response compared with the model.
    task automatic issue(input logic [15:0] a);
        bit exp_hit [3];
        bit done [3];
        logic [15:0] blk = {a[15:3], 3'b000};
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            check(rdy[p] == 1'b1, "R4 ready before request", 32'(rdy[p]), 32'd1);
            exp_hit[p] = model_access(p, a, m_lfsr[0]);
            done[p] = 1'b0;
        end
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 1; cyc <= 40 && !(done[0] && done[1] && done[2]); cyc++) begin
            for (int p = 0; p < 3; p++) begin
                if (done[p]) begin
                    if (rv[p]) check(1'b0, "R5 extra response", 32'd1, 32'd0);
                end else begin
                    if (cyc == 1 && !exp_hit[p]) begin
                        check(frq[p] == 1'b1, "R4 fetch raised", 32'(frq[p]), 32'd1);
                        check(fa[p] == blk, "R4 fetch address", 32'(fa[p]), 32'(blk));
                    end
                    if (rv[p]) begin
                        // R6 and the policy requirement show up as hit or miss
                        check(rh[p] == exp_hit[p], pol_tag(p), 32'(rh[p]), 32'(exp_hit[p]));
                        check(rd[p] == word_of(blk, int'(a[2])), exp_hit[p] ? "R2" : "R5",
                              rd[p], word_of(blk, int'(a[2])));
                        if (exp_hit[p])
                            check(cyc == 1, "R3 hit latency", 32'(cyc), 32'd1);
                        done[p] = 1'b1;
                    end else if (exp_hit[p] && cyc == 1) begin
                        check(1'b0, "R3 hit response missing", 32'd0, 32'd1);
                    end else if (!exp_hit[p]) begin
                        check(rdy[p] == 1'b0, "R4 busy while fetching", 32'(rdy[p]), 32'd0);
                    end
                end
            end
            @(negedge clk);
        end
        for (int p = 0; p < 3; p++)
            if (!done[p]) check(1'b0, "R5 no response", 32'd0, 32'd1);
    endtask

    function automatic logic [15:0] mk(input int tag, input int idx, input int w, input int b);
        return {11'(tag), 2'(idx), 1'(w), 2'(b)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            check(rdy[p] == 1'b1, "R1 ready after reset", 32'(rdy[p]), 32'd1);
            check(rv[p] == 1'b0, "R1 no response after reset", 32'(rv[p]), 32'd0);
            check(frq[p] == 1'b0, "R1 no fetch after reset", 32'(frq[p]), 32'd0);
        end

        // R1/R6: first access misses into way 0, second tag into way 1
        issue(mk(16, 1, 0, 0));
        issue(mk(32, 1, 1, 0));
        // R2/R3: byte offset ignored, word bit selects
        issue(mk(16, 1, 1, 3));
        issue(mk(16, 1, 0, 2));
        // R7 evicts tag 16, R8 evicts tag 32, R9 follows the shift register
        issue(mk(48, 1, 0, 0));
        issue(mk(16, 1, 1, 1));
        issue(mk(32, 1, 0, 0));
        issue(mk(48, 1, 1, 0));
        // R5: refilled block is present afterwards
        issue(mk(48, 1, 1, 2));

        // Mixed traffic: few tags per set to force evictions in all policies
        for (int i = 0; i < 400; i++) begin
            int t = 100 + int'($urandom_range(0, 3));
            issue(mk(t, int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                     int'($urandom_range(0, 3))));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule